// File: doc/BRIEF.md
# Configurable Byte-Wide SPI Engine

This block moves one byte at a time over a four-wire serial link, and it can run either as the clock-generating controller or as the clocked peripheral. In controller mode a write to the data port starts a transfer. The engine then generates the serial clock from a programmable divider, shifts the byte out on the outgoing data line and, in the same eight bit times, collects a byte from the incoming line. It can also pull its own select output low around the byte. In peripheral mode the external clock and select lines pass through a synchronizer into the system clock. The engine then shifts its preloaded byte out and collects the byte sent by the far end.

Clock idle level, data phase and bit order are each selected by their own control input, and the same settings apply to both modes. A sticky completion flag goes high once the eighth bit has been sampled, and a read strobe clears it. The controller's automatic select output is driven only when two separate enable inputs are both high. In the second-edge data phase, a peripheral may stay selected across consecutive bytes.

Top module: `spi8_core`

## Requirements
- R1: While reset is held, `sck_out` is low, `ssel_out_n` is high, `done_flag` is low and `rd_data` is zero.
- R2: In controller mode, a write with no transfer running produces exactly 16 clock edges. The edges are spaced H system clocks apart, with the first edge H clocks after the write is taken, where H equals `cfg_div`. Whenever no transfer is running, `sck_out` rests at `cfg_cpol` (0 = low, 1 = high).
- R3: `ssel_out_n` goes low in the cycle after the starting write and stays low through edge 15, but only when `cfg_fault_en` and `cfg_ssel_en` are both 1. Otherwise it stays high for the whole transfer.
- R4: `ssel_out_n` returns high in the same cycle as the 16th clock edge, and the transfer ends there.
- R5: With `cfg_cpha` = 0, the first data bit is on the outgoing line before the first edge. Odd-numbered edges (1, 3, …, 15) sample, and even-numbered edges present the next bit.
- R6: With `cfg_cpha` = 1, odd-numbered edges present a data bit, with the first bit appearing at edge 1. Even-numbered edges (2, …, 16) sample.
- R7: With `cfg_lsb_first` = 0, bit 7 goes first and bit 0 goes last. With `cfg_lsb_first` = 1, bit 0 goes first. Received bits are placed in the same order.
- R8: After the eighth sampling edge, `rd_data` holds the received byte and `done_flag` is 1. A one-cycle `rd_en` pulse clears the flag.
- R9: A write that arrives while a controller transfer is running is ignored. The byte on the line is not altered, and no second transfer follows.
- R10: In peripheral mode, a byte written while deselected is shifted out on `miso_out`, and the byte arriving on `mosi_in` lands in `rd_data`. With `cfg_cpha` = 0 the first bit appears on select assertion, and the select line must be released between bytes. With `cfg_cpha` = 1 the select line may stay low across back-to-back bytes, and a byte written between them is taken.
- R11: A divider value of 0 behaves exactly like a divider value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = controller mode, 0 = peripheral mode |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Data phase: 0 = sample on odd edges, 1 = sample on even edges |
| cfg_lsb_first | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| cfg_fault_en | input | 1 | First enable for the automatic select output |
| cfg_ssel_en | input | 1 | Second enable for the automatic select output |
| cfg_div | input | DIV_W | Half clock period in system clocks (0 treated as 1) |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Read strobe, clears the completion flag |
| rd_data | output | 8 | Last received byte |
| done_flag | output | 1 | Byte completed, sticky until read |
| sck_out | output | 1 | Serial clock driven in controller mode |
| mosi_out | output | 1 | Outgoing data in controller mode |
| ssel_out_n | output | 1 | Automatic select output, active low |
| miso_in | input | 1 | Incoming data in controller mode |
| sck_in | input | 1 | External serial clock in peripheral mode |
| ssel_in_n | input | 1 | Select input in peripheral mode, active low |
| mosi_in | input | 1 | Incoming data in peripheral mode |
| miso_out | output | 1 | Outgoing data in peripheral mode |

## Verification
Some rules are checked by the bound assertions on every cycle. The serial clock sits at its idle level between transfers and moves only on a divider strobe. The select output is low only inside a transfer whose enables were set, and it is released on the final edge. Output and sampling events never coincide, and the completion flag rises only on the eighth sample and falls after a read. Other behaviour can only be seen at the pins over whole scenarios, and the bench checks it there. This covers the order in which bits appear and are captured under each phase and bit-order setting, and the exact spacing of the edges for each divider value. It also covers rejecting a write in the middle of a byte and the back-to-back peripheral bytes under a select line held low.

// File: rtl/spi8_pkg.sv
package spi8_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned EDGE_TOTAL = 2 * BYTE_W;
  localparam int unsigned EDGE_W     = $clog2(EDGE_TOTAL);
  localparam int unsigned SMP_W      = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  // Bit that leaves the shifter next, for the selected order.
  function automatic logic head_bit(input byte_t v, input logic lsb_first);
    return lsb_first ? v[0] : v[BYTE_W-1];
  endfunction

  // Shifter contents after the head bit has been sent.
  function automatic byte_t drop_head(input byte_t v, input logic lsb_first);
    return lsb_first ? {1'b0, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], 1'b0};
  endfunction

  // Receive register after one more sampled bit.
  function automatic byte_t push_bit(input byte_t v, input logic b, input logic lsb_first);
    return lsb_first ? {b, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], b};
  endfunction

  // Terminal tick count of one half period; a zero divider acts as one.
  function automatic logic [31:0] half_limit(input logic [31:0] d);
    return (d == 32'd0) ? 32'd0 : d - 32'd1;
  endfunction
endpackage

// File: rtl/spi8_sync.sv
module spi8_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi8_baud.sv
module spi8_baud
  import spi8_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic              busy,
  output logic              strobe,
  output logic              last,
  output logic [EDGE_W-1:0] edge_idx
);
  logic [DIV_W-1:0]  tick_q;
  logic [DIV_W-1:0]  lim;
  logic [EDGE_W-1:0] cnt_q;
  logic              busy_q;

  assign lim      = DIV_W'(half_limit(32'(cfg_div)));
  assign strobe   = busy_q && (tick_q >= lim);
  assign last     = strobe && (cnt_q == EDGE_W'(EDGE_TOTAL - 1));
  assign busy     = busy_q;
  assign edge_idx = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tick_q <= '0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      tick_q <= '0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (strobe) begin
        tick_q <= '0;
        cnt_q  <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi8_shifter.sv
module spi8_shifter
  import spi8_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_val,
  input  logic  out_evt,
  input  logic  smp_evt,
  input  logic  smp_bit,
  input  logic  lsb_first,
  output logic  line_out,
  output byte_t rx_next
);
  byte_t sr_q, rx_q, base;
  logic  line_q;

  assign base     = load ? load_val : sr_q;
  assign rx_next  = push_bit(rx_q, smp_bit, lsb_first);
  assign line_out = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      rx_q   <= '0;
      line_q <= 1'b0;
    end else begin
      if (out_evt) begin
        line_q <= head_bit(base, lsb_first);
        sr_q   <= drop_head(base, lsb_first);
      end else if (load) begin
        sr_q <= load_val;
      end
      if (smp_evt) rx_q <= rx_next;
    end
  end
endmodule

// File: rtl/spi8_core.sv
module spi8_core
  import spi8_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_lsb_first,
  input  logic             cfg_fault_en,
  input  logic             cfg_ssel_en,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             done_flag,
  output logic             sck_out,
  output logic             mosi_out,
  output logic             ssel_out_n,
  input  logic             miso_in,
  input  logic             sck_in,
  input  logic             ssel_in_n,
  input  logic             mosi_in,
  output logic             miso_out
);
  // Peripheral-side inputs brought into the system clock
  logic sck_s, ssn_s, mosi_s, sck_d, ssn_d;

  spi8_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_in, ssel_in_n, mosi_in}),
    .q({sck_s, ssn_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      ssn_d <= 1'b1;
    end else begin
      sck_d <= sck_s;
      ssn_d <= ssn_s;
    end
  end

  // Named events used by logic and by the checker
  logic              s_sel, s_edge, s_sel_start, s_load;
  logic [EDGE_W-1:0] s_cnt_q;
  logic              m_start, m_busy, m_strobe, m_last;
  logic [EDGE_W-1:0] m_cnt;
  logic              edge_fire, edge_odd, out_evt, smp_evt, smp_bit, byte_end;
  logic [SMP_W-1:0]  smp_cnt_q;
  byte_t             rx_next, rd_q;
  logic              done_q, sck_q, ssel_q;

  assign s_sel       = !cfg_master && !ssn_s;
  assign s_edge      = s_sel && (sck_s != sck_d);
  assign s_sel_start = !cfg_master && ssn_d && !ssn_s;
  assign s_load      = !cfg_master && wr_en && (s_cnt_q == '0) && (cfg_cpha || !s_sel);
  assign m_start     = cfg_master && wr_en && !m_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      s_cnt_q <= '0;
    else if (!s_sel) s_cnt_q <= '0;
    else if (s_edge) s_cnt_q <= s_cnt_q + 1'b1;
  end

  spi8_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .start(m_start), .cfg_div(cfg_div),
    .busy(m_busy), .strobe(m_strobe), .last(m_last), .edge_idx(m_cnt)
  );

  // Edge numbering starts at 1, so an even count before the edge means an odd edge
  assign edge_fire = cfg_master ? m_strobe : s_edge;
  assign edge_odd  = cfg_master ? ~m_cnt[0] : ~s_cnt_q[0];
  assign out_evt   = (edge_fire && (edge_odd == cfg_cpha)) ||
                     (!cfg_cpha && (m_start || s_sel_start));
  assign smp_evt   = edge_fire && (edge_odd != cfg_cpha);
  assign smp_bit   = cfg_master ? miso_in : mosi_s;
  assign byte_end  = smp_evt && (smp_cnt_q == SMP_W'(BYTE_W - 1));

  spi8_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(m_start || s_load), .load_val(wr_data),
    .out_evt(out_evt), .smp_evt(smp_evt), .smp_bit(smp_bit),
    .lsb_first(cfg_lsb_first), .line_out(mosi_out), .rx_next(rx_next)
  );
  assign miso_out = mosi_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_cnt_q <= '0;
      done_q    <= 1'b0;
      rd_q      <= '0;
      sck_q     <= 1'b0;
      ssel_q    <= 1'b1;
    end else begin
      if (m_start || (!cfg_master && !s_sel)) smp_cnt_q <= '0;
      else if (smp_evt)                       smp_cnt_q <= smp_cnt_q + 1'b1;

      if (byte_end) begin
        done_q <= 1'b1;
        rd_q   <= rx_next;
      end else if (rd_en) begin
        done_q <= 1'b0;
      end

      if (!m_busy)       sck_q <= cfg_cpol;
      else if (m_strobe) sck_q <= ~sck_q;

      if (m_start)     ssel_q <= ~(cfg_fault_en && cfg_ssel_en);
      else if (m_last) ssel_q <= 1'b1;
    end
  end

  assign rd_data    = rd_q;
  assign done_flag  = done_q;
  assign sck_out    = sck_q;
  assign ssel_out_n = ssel_q;
endmodule

// File: rtl/spi8_checker.sv
module spi8_checker
  import spi8_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_cpol,
  input logic             cfg_fault_en,
  input logic             cfg_ssel_en,
  input logic             m_busy,
  input logic             m_strobe,
  input logic             m_last,
  input logic             sck_out,
  input logic             ssel_out_n,
  input logic             out_evt,
  input logic             smp_evt,
  input logic [SMP_W-1:0] smp_cnt_q,
  input logic             done_flag,
  input logic             rd_en
);
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !m_busy |=> (sck_out == $past(cfg_cpol)));

  p_sck_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_busy && !m_strobe) |=> $stable(sck_out));

  p_ss_in_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ssel_out_n |-> m_busy);

  p_ss_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssel_out_n) |-> $past(cfg_fault_en && cfg_ssel_en));

  p_ss_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |=> (ssel_out_n && !m_busy));

  p_evt_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_evt && smp_evt));

  p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(smp_evt && (smp_cnt_q == SMP_W'(BYTE_W - 1))));

  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && rd_en && !smp_evt) |=> !done_flag);
endmodule

bind spi8_core spi8_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol),
  .cfg_fault_en(cfg_fault_en), .cfg_ssel_en(cfg_ssel_en),
  .m_busy(m_busy), .m_strobe(m_strobe), .m_last(m_last),
  .sck_out(sck_out), .ssel_out_n(ssel_out_n),
  .out_evt(out_evt), .smp_evt(smp_evt), .smp_cnt_q(smp_cnt_q),
  .done_flag(done_flag), .rd_en(rd_en)
);

// File: tb/test_spi8_core.sv
module test_spi8_core;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_master, cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_fault_en, cfg_ssel_en;
  logic [DIV_W-1:0] cfg_div;
  logic wr_en, rd_en, miso_in, sck_in, ssel_in_n, mosi_in;
  logic [7:0] wr_data, rd_data;
  logic done_flag, sck_out, mosi_out, ssel_out_n, miso_out;

  int errors = 0;
  int checks = 0;

  spi8_core #(.DIV_W(DIV_W)) i_spi8_core (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_fault_en(cfg_fault_en),
    .cfg_ssel_en(cfg_ssel_en), .cfg_div(cfg_div), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .done_flag(done_flag), .sck_out(sck_out),
    .mosi_out(mosi_out), .ssel_out_n(ssel_out_n), .miso_in(miso_in), .sck_in(sck_in),
    .ssel_in_n(ssel_in_n), .mosi_in(mosi_in), .miso_out(miso_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Bit sent in position idx (0 = first on the wire)
  function automatic logic wire_bit(input logic [7:0] b, input int idx, input logic lsb);
    return lsb ? b[idx] : b[7-idx];
  endfunction

  function automatic logic [7:0] place_bit(input logic [7:0] b, input int idx,
                                           input logic v, input logic lsb);
    logic [7:0] r = b;
    if (lsb) r[idx] = v; else r[7-idx] = v;
    return r;
  endfunction

  function automatic int half_of(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic read_clear(input string tag);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(done_flag == 1'b0, tag, done_flag, 0);
  endtask

  task automatic run_master(input logic [7:0] tx, input logic [7:0] peer,
                            input logic cpol, input logic cpha, input logic lsb,
                            input int div, input logic fe, input logic se, input bit poke);
    int h = half_of(div);
    int c = 0, last_c = 0, e = 0;
    bit gap_ok = 1, ss_ok = 1, poked = 0;
    logic exp_ss_n = !(fe && se);
    logic prev;
    logic [7:0] got = 8'h00;
    @(negedge clk);
    cfg_master = 1'b1; cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
    cfg_fault_en = fe; cfg_ssel_en = se; cfg_div = DIV_W'(div);
    miso_in = wire_bit(peer, 0, lsb);
    @(negedge clk);
    @(negedge clk);
    chk(sck_out == cpol, "R2 idle level before transfer", sck_out, cpol);
    wr_data = tx; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(ssel_out_n == exp_ss_n, "R3 select at start", ssel_out_n, exp_ss_n);
    if (!cpha) chk(mosi_out == wire_bit(tx, 0, lsb), "R5 first bit before edge 1",
                   mosi_out, wire_bit(tx, 0, lsb));
    prev = sck_out;
    while (e < 16 && c < 400) begin
      @(negedge clk);
      c++;
      if (wr_en) wr_en = 1'b0;
      if (sck_out != prev) begin
        e++;
        prev = sck_out;
        if (c - last_c != h) gap_ok = 0;
        last_c = c;
        if (e < 16 && ssel_out_n != exp_ss_n) ss_ok = 0;
        if (((e % 2) == 1) != cpha) begin
          got = place_bit(got, (e - 1) / 2, mosi_out, lsb);
        end else begin
          int idx = cpha ? (e - 1) / 2 : e / 2;
          if (idx < 8) miso_in = wire_bit(peer, idx, lsb);
        end
        if (poke && !poked && e == 5) begin
          wr_data = ~tx; wr_en = 1'b1; poked = 1;
        end
      end
    end
    chk(e == 16, "R2 edge count", e, 16);
    chk(gap_ok, (div == 0) ? "R11 zero divider spacing" : "R2 edge spacing", gap_ok, 1);
    chk(ss_ok, "R3 select held through edge 15", ss_ok, 1);
    chk(ssel_out_n == 1'b1, "R4 select released at edge 16", ssel_out_n, 1);
    chk(got == tx, poke ? "R9 write during transfer ignored" :
        (cpha ? "R6 bits out, order per R7" : "R5 bits out, order per R7"), got, tx);
    chk(done_flag == 1'b1, "R8 done flag set", done_flag, 1);
    chk(rd_data == peer, "R8 received byte (order per R7)", rd_data, peer);
    read_clear("R8 done flag cleared by read");
    if (poke) begin
      int moved = 0;
      for (int k = 0; k < 4 * h + 4; k++) begin
        @(negedge clk);
        if (sck_out != cpol) moved++;
      end
      chk(moved == 0, "R9 no second transfer", moved, 0);
    end
  endtask

  task automatic run_slave(input logic [7:0] s0, input logic [7:0] s1,
                           input logic [7:0] m0, input logic [7:0] m1,
                           input int nb, input logic cpha, input logic lsb, input logic cpol);
    @(negedge clk);
    cfg_master = 1'b0; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_cpol = cpol;
    sck_in = cpol; ssel_in_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      logic [7:0] stx = (b == 0) ? s0 : s1;
      logic [7:0] mtx = (b == 0) ? m0 : m1;
      logic [7:0] got = 8'h00;
      if (b > 0 && !cpha) begin
        ssel_in_n = 1'b1;
        repeat (8) @(negedge clk);
      end
      wr_data = stx; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      repeat (4) @(negedge clk);
      if (ssel_in_n) begin
        ssel_in_n = 1'b0;
        if (!cpha) mosi_in = wire_bit(mtx, 0, lsb);
      end
      repeat (8) @(negedge clk);
      for (int e = 1; e <= 16; e++) begin
        if (((e % 2) == 1) != cpha) begin
          got = place_bit(got, (e - 1) / 2, miso_out, lsb);
        end else begin
          int idx = cpha ? (e - 1) / 2 : e / 2;
          if (idx < 8) mosi_in = wire_bit(mtx, idx, lsb);
        end
        sck_in = ~sck_in;
        repeat (8) @(negedge clk);
      end
      chk(got == stx, (b > 0 && cpha) ? "R10 back-to-back byte out" : "R10 peripheral byte out",
          got, stx);
      chk(done_flag == 1'b1, "R8 done flag in peripheral mode", done_flag, 1);
      chk(rd_data == mtx, "R10 peripheral received byte", rd_data, mtx);
      read_clear("R8 peripheral flag cleared");
    end
    ssel_in_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd1234);
    rst_n = 1'b0; cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    cfg_lsb_first = 1'b0; cfg_fault_en = 1'b1; cfg_ssel_en = 1'b1; cfg_div = '0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00; miso_in = 1'b0;
    sck_in = 1'b0; ssel_in_n = 1'b1; mosi_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(sck_out == 1'b0, "R1 reset clock", sck_out, 0);
    chk(ssel_out_n == 1'b1, "R1 reset select", ssel_out_n, 1);
    chk(done_flag == 1'b0, "R1 reset flag", done_flag, 0);
    chk(rd_data == 8'h00, "R1 reset data", rd_data, 0);
    rst_n = 1'b1;

    run_master(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b1, 0);
    run_master(8'h96, 8'h5A, 1'b1, 1'b1, 1'b1, 2, 1'b1, 1'b1, 0);
    run_master(8'h81, 8'h7E, 1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b1, 0);
    run_master(8'hC3, 8'h18, 1'b1, 1'b0, 1'b1, 3, 1'b1, 1'b0, 0);
    run_master(8'h4D, 8'hB2, 1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b1, 0);
    run_master(8'h5B, 8'hE4, 1'b0, 1'b0, 1'b0, 2, 1'b1, 1'b1, 1);
    for (int i = 0; i < 10; i++) begin
      run_master(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 int'($urandom_range(0, 4)), 1'($urandom), 1'($urandom), 0);
    end

    run_slave(8'hD2, 8'h00, 8'h4B, 8'h00, 1, 1'b0, 1'b0, 1'b0);
    run_slave(8'h2D, 8'hB4, 8'h6A, 8'h91, 2, 1'b1, 1'b1, 1'b1);
    run_slave(8'h1F, 8'hE0, 8'hC5, 8'h3A, 2, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      run_slave(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 2,
                1'($urandom), 1'($urandom), 1'($urandom));
    end

    summary();
    $finish;
  end
endmodule